// File: doc/BRIEF.md
# Set-Associative Data Translation Buffer

This block caches translations from virtual page numbers to physical page numbers for 4 KiB pages. It holds 64 entries, organised as 16 sets of 4 ways. A requester presents a virtual address on the lookup port. In the same cycle it receives either a physical address or an abort. The physical address is the cached physical page number joined to the untranslated 12-bit page offset. An abort tells the requester to hold the access and replay it later.

A separate page-walk agent installs translations through the fill port, independently of lookups. A fill whose page number equals the page number being looked up in that cycle also forwards its translation straight to the requester, so the replay needs no second lookup.

Each set chooses a way to replace with a 3-bit tree pseudo-LRU. An invalidate-all input empties the whole buffer in one cycle.

Top module: `vpage_xlat`

## Requirements
- R1: After reset every lookup misses, with lk_abort=1 and lk_hit=0.
- R2: A lookup that finds a valid entry gives lk_hit=1, lk_abort=0 and lk_paddr = {stored physical page, lk_vaddr[11:0]} in the same cycle.
- R3: A lookup that neither finds an entry nor is forwarded gives lk_abort=1, lk_hit=0 and lk_paddr=0. No translation is produced.
- R4: The set index is VPN[3:0], where VPN = lk_vaddr[31:12]. The stored tag is VPN[19:4]. A set holds up to 4 distinct tags at once, and a fill is visible to lookups from the next cycle.
- R5: A fill writes into the way that already holds its VPN if there is one. Otherwise it writes into the lowest-numbered invalid way. Otherwise it writes into the pseudo-LRU victim.
- R6: Each set keeps tree bits t[2:0], all 0 after reset. The victim is t0 ? (t2 ? 3 : 2) : (t1 ? 1 : 0). Touching way w sets t0 = (w<2), and then sets t1 = (w==0) if w<2, or t2 = (w==2) otherwise. A lookup hit touches its way. A fill touches the way it writes. A fill wins when both land in the same set.
- R7: When fill_valid=1 and fill_vpn equals the lookup VPN, the lookup returns lk_hit=1 and lk_fwd=1 with lk_paddr = {fill_ppn, lk_vaddr[11:0]}. Otherwise lk_fwd=0.
- R8: A lookup in the same cycle as a fill to the same set sees the contents from before the fill, unless R7 applies.
- R9: inv_all clears every valid bit at the next clock edge. A fill in the same cycle is dropped. The pseudo-LRU bits are kept.
- R10: With lk_valid=0, lk_hit, lk_abort and lk_fwd are 0, lk_paddr is 0, and the pseudo-LRU bits are not changed by the lookup port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Translation delivered |
| lk_abort | output | 1 | Miss: requester must replay |
| lk_fwd | output | 1 | Translation forwarded from the fill port |
| lk_paddr | output | 32 | Translated physical address |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_ppn | input | 20 | Physical page number being installed |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The lookup results are combinational, so they are due in the same cycle as the address. Fills, invalidation and pseudo-LRU updates take effect at the next rising edge and are first seen by the lookup in the following cycle. The bench drives inputs on the falling edge and samples outputs 5 ns later, before the rising edge. It then advances its own reference model across that edge. Every comparison therefore sees the state from before the edge, which is exactly what R8 requires.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int OFS_W = 12;

  typedef enum logic [1:0] {
    FSRC_MATCH = 2'd0,
    FSRC_FREE  = 2'd1,
    FSRC_PLRU  = 2'd2
  } fill_src_e;
endpackage

// File: rtl/xlat_array.sv
module xlat_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_set,
  output logic [WAYS-1:0]  rd_valid,
  output logic [TAG_W-1:0] rd_tag [WAYS],
  output logic [PPN_W-1:0] rd_ppn [WAYS],
  input  logic [IDX_W-1:0] fl_set,
  output logic [WAYS-1:0]  fl_valid,
  output logic [TAG_W-1:0] fl_tag [WAYS],
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             inv_all
);
  logic [WAYS-1:0]  vld [SETS];
  logic [TAG_W-1:0] tag [SETS][WAYS];
  logic [PPN_W-1:0] ppn [SETS][WAYS];

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      assign rd_tag[w] = tag[rd_set][w];
      assign rd_ppn[w] = ppn[rd_set][w];
      assign fl_tag[w] = tag[fl_set][w];
    end
  endgenerate

  assign rd_valid = vld[rd_set];
  assign fl_valid = vld[fl_set];

  always_ff @(posedge clk) begin
    if (!rst_n || inv_all) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (wr_en) begin
      vld[fl_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) begin
      tag[fl_set][wr_way] <= wr_tag;
      ppn[fl_set][wr_way] <= wr_ppn;
    end
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [TAG_W-1:0] tags [WAYS],
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic [WAY_W-1:0] hit_idx
);
  logic [WAYS-1:0] eq;

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = valid[w] && (tags[w] == key);
    end
  endgenerate

  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (eq[i]) hit_idx = WAY_W'(i);
  end
endmodule

// File: rtl/xlat_plru.sv
module xlat_plru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int T_W   = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] victim
);
  logic [T_W-1:0] st [SETS];

  function automatic logic [T_W-1:0] touch(input logic [T_W-1:0] t,
                                           input logic [WAY_W-1:0] w);
    int node;
    logic b;
    touch = t;
    node  = 0;
    for (int l = 0; l < WAY_W; l++) begin
      b           = w[WAY_W-1-l];
      touch[node] = ~b;
      node        = 2 * node + 1 + int'(b);
    end
  endfunction

  function automatic logic [WAY_W-1:0] pick(input logic [T_W-1:0] t);
    int node;
    node = 0;
    for (int l = 0; l < WAY_W; l++)
      node = 2 * node + 1 + int'(t[node]);
    pick = WAY_W'(node - T_W);
  endfunction

  assign victim = pick(st[fill_set]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) st[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (fill_en && fill_set == IDX_W'(s))
          st[s] <= touch(st[s], fill_way);
        else if (hit_en && hit_set == IDX_W'(s))
          st[s] <= touch(st[s], hit_way);
      end
    end
  end
endmodule

// File: rtl/vpage_xlat.sv
module vpage_xlat #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int VPN_W = VA_W - xlat_pkg::OFS_W,
  localparam int PPN_W = PA_W - xlat_pkg::OFS_W,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_abort,
  output logic             lk_fwd,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_all
);
  import xlat_pkg::*;

  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag_in;

  assign lk_vpn    = lk_vaddr[VA_W-1:OFS_W];
  assign lk_set    = lk_vpn[IDX_W-1:0];
  assign lk_tag    = lk_vpn[VPN_W-1:IDX_W];
  assign fl_set    = fill_vpn[IDX_W-1:0];
  assign fl_tag_in = fill_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0]  rd_valid, fl_valid;
  logic [TAG_W-1:0] rd_tag [WAYS];
  logic [TAG_W-1:0] fl_tag [WAYS];
  logic [PPN_W-1:0] rd_ppn [WAYS];
  logic             do_fill;
  logic [WAY_W-1:0] fill_way;

  assign do_fill = fill_valid && !inv_all;

  xlat_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_set(lk_set), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_ppn(rd_ppn),
    .fl_set(fl_set), .fl_valid(fl_valid), .fl_tag(fl_tag),
    .wr_en(do_fill), .wr_way(fill_way), .wr_tag(fl_tag_in), .wr_ppn(fill_ppn),
    .inv_all(inv_all)
  );

  // lookup side
  logic             arr_hit;
  logic [WAY_W-1:0] arr_way;

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid(rd_valid), .tags(rd_tag), .key(lk_tag),
    .hit(arr_hit), .hit_idx(arr_way)
  );

  logic             fwd_ev, hit_ev, hit_touch;
  logic [PPN_W-1:0] out_ppn;

  assign fwd_ev    = lk_valid && fill_valid && (fill_vpn == lk_vpn);
  assign hit_ev    = lk_valid && (arr_hit || fwd_ev);
  assign out_ppn   = fwd_ev ? fill_ppn : rd_ppn[arr_way];
  assign hit_touch = lk_valid && arr_hit && !(do_fill && fl_set == lk_set);

  assign lk_hit   = hit_ev;
  assign lk_fwd   = fwd_ev;
  assign lk_abort = lk_valid && !hit_ev;
  assign lk_paddr = hit_ev ? {out_ppn, lk_vaddr[OFS_W-1:0]} : '0;

  // fill side: reuse, then free, then pseudo-LRU victim
  logic             fl_match;
  logic [WAY_W-1:0] fl_match_way, free_way, plru_way;
  logic             has_free;
  fill_src_e        fill_src;

  xlat_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .valid(fl_valid), .tags(fl_tag), .key(fl_tag_in),
    .hit(fl_match), .hit_idx(fl_match_way)
  );

  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!fl_valid[i]) begin
        has_free = 1'b1;
        free_way = WAY_W'(i);
      end
    end
  end

  always_comb begin
    if (fl_match)      fill_src = FSRC_MATCH;
    else if (has_free) fill_src = FSRC_FREE;
    else               fill_src = FSRC_PLRU;
    case (fill_src)
      FSRC_MATCH: fill_way = fl_match_way;
      FSRC_FREE:  fill_way = free_way;
      default:    fill_way = plru_way;
    endcase
  end

  xlat_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .hit_en(hit_touch), .hit_set(lk_set), .hit_way(arr_way),
    .fill_en(do_fill), .fill_set(fl_set), .fill_way(fill_way),
    .victim(plru_way)
  );
endmodule

// File: rtl/vpage_xlat_chk.sv
module vpage_xlat_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lk_valid,
  input logic [VA_W-1:0]     lk_vaddr,
  input logic                lk_hit,
  input logic                lk_abort,
  input logic                lk_fwd,
  input logic [PA_W-1:0]     lk_paddr,
  input logic                fill_valid,
  input logic [VA_W-13:0]    fill_vpn,
  input logic [PA_W-13:0]    fill_ppn,
  input logic                inv_all,
  input logic                do_fill
);
  a_r3_hit_xor_abort: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_abort));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_abort && !lk_fwd && lk_paddr == '0));

  a_r2_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

  a_r7_fwd_ppn: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fwd |-> (fill_valid && lk_hit && lk_paddr[PA_W-1:12] == fill_ppn));

  a_r9_inv_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_all) && lk_valid && !lk_fwd) |-> !lk_hit);

  a_r4_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(do_fill) && lk_valid && lk_vaddr[VA_W-1:12] == $past(fill_vpn)) |-> lk_hit);
endmodule

bind vpage_xlat vpage_xlat_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_abort(lk_abort), .lk_fwd(lk_fwd), .lk_paddr(lk_paddr),
  .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
  .inv_all(inv_all), .do_fill(do_fill)
);

// File: tb/vpage_xlat_tb.sv
module vpage_xlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_abort, lk_fwd;
  logic [31:0] lk_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        inv_all = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vpage_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_abort(lk_abort), .lk_fwd(lk_fwd), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .inv_all(inv_all)
  );

  // reference model
  bit          mv [16][4];
  logic [15:0] mt [16][4];
  logic [19:0] mp [16][4];
  logic [2:0]  mpl [16];

  function automatic int m_victim(logic [2:0] t);
    if (t[0]) return t[2] ? 3 : 2;
    return t[1] ? 1 : 0;
  endfunction

  function automatic logic [2:0] m_touch(logic [2:0] t, int w);
    logic [2:0] r = t;
    r[0] = (w < 2);
    if (w < 2) r[1] = (w == 0);
    else       r[2] = (w == 2);
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int s = 0; s < 16; s++) begin
      mpl[s] = 3'b000;
      for (int w = 0; w < 4; w++) mv[s][w] = 0;
    end
  endtask

  // one cycle: drive, sample, advance model
  task automatic step(bit lv, logic [31:0] va, bit fv, logic [19:0] fvpn,
                      logic [19:0] fppn, bit inv, string req);
    int s, fs, hw, fw;
    bit ah, ef, eh, fm;
    logic [31:0] ep;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; fill_valid = fv; fill_vpn = fvpn;
    fill_ppn = fppn; inv_all = inv;
    s = int'(va[15:12]);
    ah = 0; hw = 0;
    for (int w = 3; w >= 0; w--)
      if (mv[s][w] && mt[s][w] == va[31:16]) begin ah = 1; hw = w; end
    ef = lv && fv && (fvpn == va[31:12]);
    eh = lv && (ah || ef);
    ep = eh ? {(ef ? fppn : mp[s][hw]), va[11:0]} : 32'h0;
    #5;
    chk(lk_hit == eh, req, "hit", 32'(lk_hit), 32'(eh));
    chk(lk_abort == (lv && !eh), req, "abort", 32'(lk_abort), 32'(lv && !eh));
    chk(lk_fwd == ef, req, "fwd", 32'(lk_fwd), 32'(ef));
    chk(lk_paddr == ep, req, "paddr", lk_paddr, ep);
    @(posedge clk);
    fs = int'(fvpn[3:0]);
    if (lv && ah && !(fv && !inv && fs == s)) mpl[s] = m_touch(mpl[s], hw);
    if (fv && !inv) begin
      fm = 0; fw = 0;
      for (int w = 3; w >= 0; w--)
        if (mv[fs][w] && mt[fs][w] == fvpn[19:4]) begin fm = 1; fw = w; end
      if (!fm) begin
        fw = -1;
        for (int w = 3; w >= 0; w--) if (!mv[fs][w]) fw = w;
        if (fw < 0) fw = m_victim(mpl[fs]);
      end
      mv[fs][fw] = 1; mt[fs][fw] = fvpn[19:4]; mp[fs][fw] = fppn;
      mpl[fs] = m_touch(mpl[fs], fw);
    end
    if (inv) for (int a = 0; a < 16; a++) for (int b = 0; b < 4; b++) mv[a][b] = 0;
  endtask

  function automatic logic [19:0] mk_vpn(int tag, int set);
    return {16'(tag), 4'(set)};
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    m_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    for (int s = 0; s < 16; s++)
      step(1, {mk_vpn(s * 3 + 1, s), 12'h5a5}, 0, 0, 0, 0, "R1");

    // R10: idle lookups quiet
    step(0, 32'hffff_f123, 0, 0, 0, 0, "R10");

    // R4 / R5: fill 4 tags into every set (free ways in order)
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        step(0, 0, 1, mk_vpn(16'h100 + w * 7, s), 20'(s * 64 + w * 5 + 3), 0, "R5");

    // R2 / R4: every entry hits with its own offset
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++)
        step(1, {mk_vpn(16'h100 + w * 7, s), 12'(s * 251 + w * 97)}, 0, 0, 0, 0, "R2");

    // R3: unknown tag in a full set misses
    step(1, {mk_vpn(16'h999, 5), 12'h001}, 0, 0, 0, 0, "R3");

    // R10: lookup port disabled does not disturb pseudo-LRU
    step(0, {mk_vpn(16'h100, 2), 12'h0}, 0, 0, 0, 0, "R10");

    // R6 / R5: eviction by pseudo-LRU in set 2, then re-look
    step(1, {mk_vpn(16'h100 + 7, 2), 12'h0}, 0, 0, 0, 0, "R6");
    step(0, 0, 1, mk_vpn(16'h777, 2), 20'hABCDE, 0, "R6");
    for (int w = 0; w < 4; w++)
      step(1, {mk_vpn(16'h100 + w * 7, 2), 12'h0}, 0, 0, 0, 0, "R6");

    // R5: refill of an existing VPN overwrites in place
    step(0, 0, 1, mk_vpn(16'h777, 2), 20'h12345, 0, "R5");
    step(1, {mk_vpn(16'h777, 2), 12'hfed}, 0, 0, 0, 0, "R5");

    // R7: forward in the fill cycle
    step(1, {mk_vpn(16'h4242, 9), 12'h321}, 1, mk_vpn(16'h4242, 9), 20'h0BEEF, 0, "R7");
    step(1, {mk_vpn(16'h4242, 9), 12'h322}, 0, 0, 0, 0, "R7");

    // R8: same-set fill and lookup, lookup sees old contents
    step(1, {mk_vpn(16'h5151, 11), 12'h0}, 1, mk_vpn(16'h6161, 11), 20'h11111, 0, "R8");
    step(1, {mk_vpn(16'h100, 11), 12'h0}, 1, mk_vpn(16'h6262, 11), 20'h22222, 0, "R8");
    step(1, {mk_vpn(16'h6262, 11), 12'h0}, 0, 0, 0, 0, "R8");

    // R9: invalidate-all with a dropped fill, then all miss
    step(1, {mk_vpn(16'h100, 0), 12'h0}, 1, mk_vpn(16'h3333, 4), 20'h33333, 1, "R9");
    for (int s = 0; s < 16; s++)
      step(1, {mk_vpn(16'h100, s), 12'h0}, 0, 0, 0, 0, "R9");
    step(1, {mk_vpn(16'h3333, 4), 12'h0}, 0, 0, 0, 0, "R9");

    // R5 / R6 / R8: pseudo-random mix on a small address space
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr;
      step(r[0] | r[1], {mk_vpn(int'(r[4:2]), int'(r[6:5])), r[15:4]},
           r[7] & r[8], mk_vpn(int'(r[11:9]), int'(r[13:12])), {r, r[3:0]},
           (r[15:10] == 6'h3f), "R5");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule